// File: doc/BRIEF.md
# ADC Conversion Slot Scheduler

This block decides which source a shared analog-to-digital converter samples next. Three kinds of source compete for the converter: a programmable set of primary voltage channels, two secondary sample-and-hold inputs, and an internal die-temperature measurement. The primary channels are walked in ascending channel order. A sample-and-hold request may take only the slot that directly follows a primary conversion, so the two kinds alternate. The temperature measurement takes one slot at the end of every pass through the channel set, and the pass then starts again.

The converter itself is abstract. The scheduler issues a one-cycle start pulse together with a source code and a result-buffer index, then waits for a done pulse before it chooses again. Each finished conversion sets a sticky completion flag for its source. Nothing starts until the internal reference has been switched on and a programmable settling countdown has run out.

Top module: `slot_sched`

## Requirements
- R1: `ref_ok` rises on the clock edge that comes SETTLE_CYCLES edges after the first edge that samples `ref_en` high. It falls on the edge after `ref_en` is sampled low. A start pulse is issued only when `ref_ok` was high in the previous cycle. The first conversion therefore starts exactly one cycle after `ref_ok` rises.
- R2: Enabled primary channels (`ch_mask` bit n = 1) are converted in ascending channel order, and disabled channels are skipped.
- R3: While `ch_mask` is non-zero, a sample-and-hold conversion is granted only in the slot right after a primary conversion, so two secondary conversions never follow each other.
- R4: When both sample-and-hold requests are pending for one secondary slot, S/H0 wins. The next contested secondary slot then goes to S/H1.
- R5: When the channel pass is exhausted and `temp_en` is high, one temperature conversion is granted. After it, the pass restarts from the lowest enabled channel.
- R6: Source codes are: channel n gives code n, S/H0 gives NUM_CH, S/H1 gives NUM_CH+1, and temperature gives NUM_CH+2. Buffer indices are: channel n gives n, S/H0 gives 23, S/H1 gives 24, and temperature gives 25.
- R7: `done_flags` bit k (k = source code) is set on the edge that samples `conv_done` for source k. It stays set until a 1 is written to `flag_clr` bit k; a set on the same edge wins over the clear.
- R8: A sample-and-hold input whose `sh_en` bit is low is never granted, and its trigger is not latched.
- R9: If no sample-and-hold request is pending when a secondary slot comes up, the next primary channel starts at once and no idle slot is inserted.
- R10: `conv_start` is a one-cycle pulse. No new start is issued until `conv_done` has been seen for the current conversion. A `conv_done` received while idle changes nothing.
- R11: Dropping `run` lets the running conversion finish and then stops all starts. The sample-and-hold fairness is reset so that S/H0 is favoured again, and the next pass begins at the lowest channel.
- R12: When `ch_mask` is zero, pending sample-and-hold requests may take any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Internal reference enable |
| run | input | 1 | Sequence run control |
| ch_mask | input | NUM_CH | Primary channel enable mask |
| sh_en | input | 2 | Sample-and-hold enables |
| sh_trig | input | 2 | Sample-and-hold ready triggers, latched until served |
| temp_en | input | 1 | Temperature slot enable |
| conv_done | input | 1 | Converter finished the current conversion |
| flag_clr | input | NUM_CH+3 | Write-one-to-clear for completion flags |
| conv_start | output | 1 | One-cycle conversion start |
| conv_src | output | $clog2(NUM_CH+3) | Selected source code |
| conv_buf | output | BUF_W | Destination result buffer index |
| ref_ok | output | 1 | Reference settled |
| done_flags | output | NUM_CH+3 | Sticky per-source completion flags |

## Verification
A wrong channel pointer shows at the ports on the very next start pulse: the source code is out of ascending order, or the temperature slot comes at the wrong place. A stale fairness bit shows on the next contested secondary slot, which is at most two conversions later, as the wrong sample-and-hold code. A busy bit that is out of step with the converter shows either as a second start before done or as a stall that never restarts. A faulty reference counter moves the first start pulse away from its exact cycle.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

    // Kind of slot chosen for the next conversion
    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_PRI,
        SLOT_SH0,
        SLOT_SH1,
        SLOT_TEMP
    } slot_kind_e;

    localparam int unsigned DEF_BUF_W    = 5;
    localparam int unsigned DEF_SH0_BUF  = 23;
    localparam int unsigned DEF_SH1_BUF  = 24;
    localparam int unsigned DEF_TEMP_BUF = 25;

endpackage

// File: rtl/slot_ref_timer.sv
module slot_ref_timer #(
    parameter int unsigned SETTLE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    output logic ref_ok
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        logic             en;
        logic             ok;
        logic [CNT_W-1:0] cnt;
    } rt_t;

    rt_t rt_d, rt_q;

    always_comb begin
        rt_d    = rt_q;
        rt_d.en = ref_en;
        if (!ref_en) begin
            rt_d.cnt = '0;
            rt_d.ok  = 1'b0;
        end else if (!rt_q.en) begin
            // first cycle with the reference on: load the countdown
            rt_d.cnt = CNT_W'(SETTLE_CYCLES - 1);
            rt_d.ok  = 1'b0;
        end else if (rt_q.cnt != '0) begin
            rt_d.cnt = rt_q.cnt - CNT_W'(1);
        end else begin
            rt_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign ref_ok = rt_q.ok;

endmodule

// File: rtl/slot_chan_seek.sv
module slot_chan_seek #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned PTR_W  = 5,
    parameter int unsigned CH_W   = 4
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [PTR_W-1:0]  from_ptr,
    output logic              found,
    output logic [CH_W-1:0]   idx
);
    // Lowest enabled channel at or above from_ptr
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && (PTR_W'(i) >= from_ptr)) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/slot_sh_pick.sv
module slot_sh_pick (
    input  logic [1:0] req,
    input  logic       owe1,
    output logic       any,
    output logic       contested,
    output logic       pick
);
    always_comb begin
        any       = |req;
        contested = &req;
        // contested: S/H0 unless S/H1 is owed the slot
        pick      = contested ? owe1 : req[1];
    end

endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_sched_pkg::*;
#(
    parameter int unsigned NUM_CH        = 16,
    parameter int unsigned SETTLE_CYCLES = 100000,
    parameter int unsigned BUF_W         = DEF_BUF_W,
    parameter int unsigned SH0_BUF       = DEF_SH0_BUF,
    parameter int unsigned SH1_BUF       = DEF_SH1_BUF,
    parameter int unsigned TEMP_BUF      = DEF_TEMP_BUF,
    localparam int unsigned NSRC         = NUM_CH + 3,
    localparam int unsigned SRC_W        = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              run,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic [1:0]        sh_en,
    input  logic [1:0]        sh_trig,
    input  logic              temp_en,
    input  logic              conv_done,
    input  logic [NSRC-1:0]   flag_clr,
    output logic              conv_start,
    output logic [SRC_W-1:0]  conv_src,
    output logic [BUF_W-1:0]  conv_buf,
    output logic              ref_ok,
    output logic [NSRC-1:0]   done_flags
);
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int unsigned PTR_W = $clog2(NUM_CH + 1);

    localparam logic [SRC_W-1:0] SH0_CODE  = SRC_W'(NUM_CH);
    localparam logic [SRC_W-1:0] SH1_CODE  = SRC_W'(NUM_CH + 1);
    localparam logic [SRC_W-1:0] TEMP_CODE = SRC_W'(NUM_CH + 2);

    typedef struct packed {
        logic             busy;
        logic             start;
        logic [SRC_W-1:0] src;
        logic [BUF_W-1:0] bufi;
        logic [PTR_W-1:0] ptr;
        logic             sec_ok;
        logic             owe1;
        logic             temp_taken;
        logic [1:0]       pend;
        logic [NSRC-1:0]  flags;
    } sched_t;

    sched_t     st_d, st_q;
    slot_kind_e kind;

    logic            seek_found;
    logic [CH_W-1:0] seek_idx;
    logic [1:0]      pend_live;
    logic            sh_any, sh_contested, sh_pick;

    slot_ref_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_en(ref_en),
        .ref_ok(ref_ok)
    );

    slot_chan_seek #(
        .NUM_CH(NUM_CH),
        .PTR_W (PTR_W),
        .CH_W  (CH_W)
    ) u_seek (
        .mask    (ch_mask),
        .from_ptr(st_q.ptr),
        .found   (seek_found),
        .idx     (seek_idx)
    );

    assign pend_live = st_q.pend & sh_en;

    slot_sh_pick u_pick (
        .req      (pend_live),
        .owe1     (st_q.owe1),
        .any      (sh_any),
        .contested(sh_contested),
        .pick     (sh_pick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.pend  = pend_live | (sh_trig & sh_en);
        st_d.flags = st_q.flags & ~flag_clr;
        kind       = SLOT_NONE;

        if (st_q.busy) begin
            if (conv_done) begin
                st_d.busy = 1'b0;
                for (int i = 0; i < int'(NSRC); i++) begin
                    if (st_q.src == SRC_W'(i)) begin
                        st_d.flags[i] = 1'b1;
                    end
                end
            end
        end else if (!run) begin
            st_d.ptr        = '0;
            st_d.sec_ok     = 1'b0;
            st_d.owe1       = 1'b0;
            st_d.temp_taken = 1'b0;
        end else if (ref_ok) begin
            if (sh_any && (st_q.sec_ok || (ch_mask == '0))) begin
                kind = sh_pick ? SLOT_SH1 : SLOT_SH0;
            end else if (seek_found) begin
                kind = SLOT_PRI;
            end else if (temp_en && !st_q.temp_taken) begin
                kind = SLOT_TEMP;
            end else begin
                // end of pass: wrap to the lowest channel
                st_d.ptr        = '0;
                st_d.temp_taken = 1'b0;
            end
        end

        case (kind)
            SLOT_PRI: begin
                st_d.src    = SRC_W'(seek_idx);
                st_d.bufi   = BUF_W'(seek_idx);
                st_d.ptr    = PTR_W'(seek_idx) + PTR_W'(1);
                st_d.sec_ok = 1'b1;
            end
            SLOT_SH0: begin
                st_d.src     = SH0_CODE;
                st_d.bufi    = BUF_W'(SH0_BUF);
                st_d.pend[0] = sh_trig[0] & sh_en[0];
                st_d.sec_ok  = 1'b0;
                if (sh_contested) begin
                    st_d.owe1 = 1'b1;
                end
            end
            SLOT_SH1: begin
                st_d.src     = SH1_CODE;
                st_d.bufi    = BUF_W'(SH1_BUF);
                st_d.pend[1] = sh_trig[1] & sh_en[1];
                st_d.sec_ok  = 1'b0;
                st_d.owe1    = 1'b0;
            end
            SLOT_TEMP: begin
                st_d.src        = TEMP_CODE;
                st_d.bufi       = BUF_W'(TEMP_BUF);
                st_d.temp_taken = 1'b1;
                st_d.sec_ok     = 1'b0;
            end
            default: begin
            end
        endcase

        if (kind != SLOT_NONE) begin
            st_d.start = 1'b1;
            st_d.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_start = st_q.start;
    assign conv_src   = st_q.src;
    assign conv_buf   = st_q.bufi;
    assign done_flags = st_q.flags;

endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
    parameter int unsigned NUM_CH  = 16,
    parameter int unsigned BUF_W   = 5,
    parameter int unsigned SH0_BUF = 23,
    parameter int unsigned SH1_BUF = 24,
    localparam int unsigned NSRC   = NUM_CH + 3,
    localparam int unsigned SRC_W  = $clog2(NSRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sh_en,
    input logic             temp_en,
    input logic             conv_done,
    input logic [NSRC-1:0]  flag_clr,
    input logic             conv_start,
    input logic [SRC_W-1:0] conv_src,
    input logic [BUF_W-1:0] conv_buf,
    input logic             ref_ok,
    input logic [NSRC-1:0]  done_flags
);
    localparam logic [SRC_W-1:0] SH0_CODE  = SRC_W'(NUM_CH);
    localparam logic [SRC_W-1:0] SH1_CODE  = SRC_W'(NUM_CH + 1);
    localparam logic [SRC_W-1:0] TEMP_CODE = SRC_W'(NUM_CH + 2);

    // conversion outstanding, tracked from the ports only
    logic out_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= (out_q | conv_start) & ~conv_done;
        end
    end

    AST_START_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(ref_ok)); // R1

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !out_q); // R10

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R10

    AST_SH0_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_src == SH0_CODE) |-> $past(sh_en[0])); // R8

    AST_SH1_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_src == SH1_CODE) |-> $past(sh_en[1])); // R8

    AST_SH_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_src == SH0_CODE) |-> (conv_buf == BUF_W'(SH0_BUF))); // R6

    AST_SH1_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_src == SH1_CODE) |-> (conv_buf == BUF_W'(SH1_BUF))); // R6

    AST_TEMP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && conv_src == TEMP_CODE) |-> $past(temp_en)); // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_flags & ~flag_clr) != '0) |=>
        ((($past(done_flags) & ~$past(flag_clr)) & ~done_flags) == '0)); // R7

endmodule

bind slot_sched slot_sched_chk #(
    .NUM_CH (NUM_CH),
    .BUF_W  (BUF_W),
    .SH0_BUF(SH0_BUF),
    .SH1_BUF(SH1_BUF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_en     (sh_en),
    .temp_en   (temp_en),
    .conv_done (conv_done),
    .flag_clr  (flag_clr),
    .conv_start(conv_start),
    .conv_src  (conv_src),
    .conv_buf  (conv_buf),
    .ref_ok    (ref_ok),
    .done_flags(done_flags)
);

// File: tb/slot_sched_bench.sv
`timescale 1ns/1ps
module slot_sched_bench;
    localparam int NCH    = 8;
    localparam int SETTLE = 16;
    localparam int NS     = NCH + 3;
    localparam int SW     = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ref_en, run, temp_en, conv_done;
    logic [NCH-1:0] ch_mask;
    logic [1:0]    sh_en, sh_trig;
    logic [NS-1:0] flag_clr;
    logic          conv_start, ref_ok;
    logic [SW-1:0] conv_src;
    logic [4:0]    conv_buf;
    logic [NS-1:0] done_flags;

    int  checks = 0;
    int  fails  = 0;
    int  cycles = 0;
    bit  ended  = 1'b0;

    always #2.5 clk = ~clk;

    slot_sched #(
        .NUM_CH       (NCH),
        .SETTLE_CYCLES(SETTLE)
    ) u_slot_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_en    (ref_en),
        .run       (run),
        .ch_mask   (ch_mask),
        .sh_en     (sh_en),
        .sh_trig   (sh_trig),
        .temp_en   (temp_en),
        .conv_done (conv_done),
        .flag_clr  (flag_clr),
        .conv_start(conv_start),
        .conv_src  (conv_src),
        .conv_buf  (conv_buf),
        .ref_ok    (ref_ok),
        .done_flags(done_flags)
    );

    // mask | sh_en | trig | hold | temp | eight expected source codes
    localparam logic [45:0] TBL [4] = '{
        {8'b0111_0001, 2'b11, 2'b11, 1'b0, 1'b1, 32'h0849_56A0},
        {8'b0000_0011, 2'b11, 2'b11, 1'b1, 1'b0, 32'h0819_0819},
        {8'b0000_0000, 2'b01, 2'b11, 1'b1, 1'b0, 32'h8888_8888},
        {8'b1000_0000, 2'b00, 2'b00, 1'b0, 1'b1, 32'h7A7A_7A7A}
    };
    localparam string TAG [4] = '{"R2/R4/R9", "R3", "R8/R12", "R5"};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int buf_of(input int code);
        if (code < NCH)      return code;
        if (code == NCH)     return 23;
        if (code == NCH + 1) return 24;
        return 25;
    endfunction

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_en = 1'b0; run = 1'b0; temp_en = 1'b0; conv_done = 1'b0;
        ch_mask = '0; sh_en = '0; sh_trig = '0; flag_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (conv_start) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic finish_conv();
        repeat (2) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !ended) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            summary();
        end
    end

    initial begin
        bit            seen, early;
        logic [3:0]    code;
        logic [NS-1:0] exp_flags, snap;

        // reset state
        do_reset();
        check(conv_start == 1'b0, "R10", int'(conv_start), 0);
        check(done_flags == '0, "R7", int'(done_flags), 0);
        check(ref_ok == 1'b0, "R1", int'(ref_ok), 0);

        // R1: reference settling gates the first start
        ch_mask = 8'b0000_0001;
        run     = 1'b1;
        ref_en  = 1'b1;
        early   = 1'b0;
        repeat (SETTLE - 1) begin
            @(negedge clk);
            if (conv_start) early = 1'b1;
        end
        check(!early && !ref_ok, "R1", int'(ref_ok), 0);
        repeat (3) @(negedge clk);
        check(ref_ok == 1'b1, "R1", int'(ref_ok), 1);
        check(conv_start == 1'b1, "R1", int'(conv_start), 1);

        // R10: no further start while the conversion is outstanding
        early = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (conv_start) early = 1'b1;
        end
        check(!early, "R10", int'(early), 0);
        conv_done = 1'b1;
        run       = 1'b0;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (3) @(negedge clk);
        check(done_flags == NS'(1), "R7", int'(done_flags), 1);

        // R10: done while idle has no effect
        snap = done_flags;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        repeat (2) @(negedge clk);
        check(done_flags == snap && !conv_start, "R10", int'(done_flags), int'(snap));

        // R7: write one to clear
        flag_clr = '1;
        @(negedge clk);
        flag_clr = '0;
        check(done_flags == '0, "R7", int'(done_flags), 0);

        // table of scheduling scenarios
        for (int s = 0; s < 4; s++) begin
            do_reset();
            ch_mask = TBL[s][45:38];
            sh_en   = TBL[s][37:36];
            temp_en = TBL[s][32];
            ref_en  = 1'b1;
            if (TBL[s][33]) begin
                sh_trig = TBL[s][35:34];
            end else begin
                sh_trig = TBL[s][35:34];
                @(negedge clk);
                sh_trig = 2'b00;
            end
            repeat (SETTLE + 4) @(negedge clk);
            run = 1'b1;
            exp_flags = '0;
            for (int k = 0; k < 8; k++) begin
                code = TBL[s][31 - 4*k -: 4];
                wait_start(seen);
                check(seen && conv_src == SW'(code), TAG[s], int'(conv_src), int'(code));
                check(conv_buf == 5'(buf_of(int'(code))), "R6", int'(conv_buf), buf_of(int'(code)));
                exp_flags[code] = 1'b1;
                finish_conv();
            end
            check(done_flags == exp_flags, "R7", int'(done_flags), int'(exp_flags));
            run     = 1'b0;
            sh_trig = 2'b00;
        end

        // R11: stop mid-conversion, fairness returns to S/H0
        do_reset();
        ch_mask = 8'b0000_0001;
        sh_en   = 2'b11;
        sh_trig = 2'b11;
        ref_en  = 1'b1;
        repeat (SETTLE + 4) @(negedge clk);
        run = 1'b1;
        wait_start(seen);
        check(seen && conv_src == SW'(0), "R11", int'(conv_src), 0);
        finish_conv();
        wait_start(seen);
        check(seen && conv_src == SW'(NCH), "R4", int'(conv_src), NCH);
        run = 1'b0;
        finish_conv();
        check(done_flags[NCH] == 1'b1, "R11", int'(done_flags[NCH]), 1);
        early = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (conv_start) early = 1'b1;
        end
        check(!early, "R11", int'(early), 0);
        run = 1'b1;
        wait_start(seen);
        check(seen && conv_src == SW'(0), "R11", int'(conv_src), 0);
        finish_conv();
        wait_start(seen);
        check(seen && conv_src == SW'(NCH), "R11", int'(conv_src), NCH);
        finish_conv();

        summary();
    end

endmodule